// File: doc/BRIEF.md
# Four-Bit Pseudo-Random Sequence Generator on a Universal Shift Register

This block is a four-bit universal shift register with a two-bit mode select (hold, shift right, shift left, parallel load). In shift-right mode the serial input at the low end receives the exclusive-OR of the two bits at the far end of the register. The register therefore steps through a pseudo-random sequence that visits all fifteen nonzero states before it repeats.

The other modes let the surrounding logic seed the generator, freeze it, or shift in an arbitrary bit stream from the other end. An all-zero register is a fixed point of the XOR feedback. An auto-seed input can be enabled so that the generator leaves that state on its own in one clock. Without it, a parallel load of a nonzero value is the way out.

Bit 0 of the output is the head of the register (the end that receives the feedback). Bit 3 is the tail (the end that receives the serial-left input).

Top module: `lfsr_usr_top`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the register becomes 4'b0000 at that edge.
- R2: Mode 2'b00 (hold) leaves `q` unchanged across the edge.
- R3: Mode 2'b01 (shift right) moves every bit one place toward the tail: new `q[i]` = old `q[i-1]` for i = 1..3.
- R4: In mode 2'b01 the new `q[0]` is old `q[2]` XOR old `q[3]`.
- R5: From any nonzero seed, fifteen shift-right steps return to the seed, with no earlier return, and visit all fifteen nonzero values.
- R6: With `auto_seed` low, an all-zero register stays all zero in mode 2'b01.
- R7: With `auto_seed` high, an all-zero register in mode 2'b01 becomes 4'b0001 after one edge.
- R8: Mode 2'b10 (shift left) moves every bit one place toward the head: new `q[i]` = old `q[i+1]` for i = 0..2, and new `q[3]` = `ser_left`.
- R9: Mode 2'b11 (load) copies `load_val` into `q` synchronously.
- R10: `q` changes only at rising edges of `clk`. Changes of the inputs between edges do not show on `q`.
- R11: `auto_seed` has no effect when the register holds a nonzero value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state advances on the rising edge |
| rst | input | 1 | Synchronous active-high clear |
| mode | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 load |
| ser_left | input | 1 | Serial bit entering the tail in shift-left mode |
| load_val | input | 4 | Parallel value for load mode |
| auto_seed | input | 1 | Forces feedback to 1 when the register is all zero |
| q | output | 4 | Register contents, bit 0 = head |

## Verification
Every result of this block appears on `q` at the first rising edge after the inputs that cause it, because the only storage is the single register stage. The bench therefore drives the inputs on the falling edge, waits for one rising edge, and compares `q` one nanosecond later with the value its own model gives for that step. The period and coverage check runs fifteen such single-edge steps and compares each step separately. The check that inputs do not act between edges changes the inputs in mid-cycle and samples before the next rising edge.

// File: rtl/lfsr_usr_pkg.sv
package lfsr_usr_pkg;

    localparam int unsigned REG_W = 4;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_RIGHT = 2'b01,
        MODE_LEFT  = 2'b10,
        MODE_LOAD  = 2'b11
    } usr_mode_e;

    // Serial bits entering the two ends of the register.
    typedef struct packed {
        logic head_in;
        logic tail_in;
    } serial_pair_t;

endpackage

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned TAP_HI = 3,
    parameter int unsigned TAP_LO = 2
) (
    input  logic [WIDTH-1:0] state,
    input  logic             seed_en,
    output logic             fb,
    output logic             all_zero
);
    logic tap_xor;

    always_comb begin
        all_zero = ~|state;
        tap_xor  = state[TAP_HI] ^ state[TAP_LO];
        // The lock-up escape only contributes when the taps give 0 anyway.
        fb       = tap_xor | (seed_en & all_zero);
    end
endmodule

// File: rtl/usr_next.sv
module usr_next
    import lfsr_usr_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] state,
    input  usr_mode_e        mode,
    input  serial_pair_t     ser,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] nxt
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_low;
        logic from_high;

        if (i == 0) begin : g_head
            assign from_low = ser.head_in;
        end else begin : g_mid_lo
            assign from_low = state[i-1];
        end

        if (i == WIDTH - 1) begin : g_tail
            assign from_high = ser.tail_in;
        end else begin : g_mid_hi
            assign from_high = state[i+1];
        end

        always_comb begin
            unique case (mode)
                MODE_HOLD:  nxt[i] = state[i];
                MODE_RIGHT: nxt[i] = from_low;
                MODE_LEFT:  nxt[i] = from_high;
                MODE_LOAD:  nxt[i] = load_val[i];
                default:    nxt[i] = state[i];
            endcase
        end
    end
endmodule

// File: rtl/usr_state.sv
module usr_state #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst) state <= '0;
        else     state <= nxt;
    end
endmodule

// File: rtl/lfsr_usr_top.sv
module lfsr_usr_top
    import lfsr_usr_pkg::*;
#(
    parameter int unsigned WIDTH  = REG_W,
    parameter int unsigned TAP_HI = WIDTH - 1,
    parameter int unsigned TAP_LO = WIDTH - 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             ser_left,
    input  logic [WIDTH-1:0] load_val,
    input  logic             auto_seed,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] state;
    logic [WIDTH-1:0] nxt;
    logic             fb;
    logic             all_zero;
    usr_mode_e        mode_e;
    serial_pair_t     ser;

    assign mode_e      = usr_mode_e'(mode);
    assign ser.head_in = fb;
    assign ser.tail_in = ser_left;
    assign q           = state;

    lfsr_feedback #(.WIDTH(WIDTH), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_fb (
        .state    (state),
        .seed_en  (auto_seed),
        .fb       (fb),
        .all_zero (all_zero)
    );

    usr_next #(.WIDTH(WIDTH)) u_next (
        .state    (state),
        .mode     (mode_e),
        .ser      (ser),
        .load_val (load_val),
        .nxt      (nxt)
    );

    usr_state #(.WIDTH(WIDTH)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .nxt   (nxt),
        .state (state)
    );

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (q == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD) |=> $stable(q));

    assert_shift_right_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RIGHT) |=> (q[WIDTH-1:1] == $past(q[WIDTH-2:0])));

    assert_feedback_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RIGHT && q != '0) |=> (q[0] == ($past(q[TAP_HI]) ^ $past(q[TAP_LO]))));

    assert_lockup_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RIGHT && q == '0 && !auto_seed) |=> (q == '0));

    assert_seed_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RIGHT && q == '0 && auto_seed) |=> (q == WIDTH'(1)));

    assert_shift_left_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LEFT) |=> (q[WIDTH-1] == $past(ser_left) &&
                                 q[WIDTH-2:0] == $past(q[WIDTH-1:1])));

    assert_load_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOAD) |=> (q == $past(load_val)));

endmodule

// File: tb/sim_lfsr_usr_top.sv
`timescale 1ns/1ps
module sim_lfsr_usr_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode;
    logic       ser_left;
    logic [3:0] load_val;
    logic       auto_seed;
    logic [3:0] q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lfsr_usr_top u0 (
        .clk(clk), .rst(rst), .mode(mode), .ser_left(ser_left),
        .load_val(load_val), .auto_seed(auto_seed), .q(q)
    );

    function automatic logic [3:0] model(input logic [3:0] cur, input logic [1:0] m,
                                         input logic sl, input logic [3:0] ld,
                                         input logic seed);
        logic f;
        f = (cur[3] ^ cur[2]) | (seed & (cur == 4'b0000));
        case (m)
            2'b00:   return cur;
            2'b01:   return {cur[2:0], f};
            2'b10:   return {sl, cur[3:1]};
            default: return ld;
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: q=%b expected %b", req, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample 1 ns later.
    task automatic step(input logic [1:0] m, input logic sl, input logic [3:0] ld,
                        input logic seed, input string req);
        logic [3:0] exp;
        @(negedge clk);
        mode = m; ser_left = sl; load_val = ld; auto_seed = seed;
        exp = model(q, m, sl, ld, seed);
        @(posedge clk); #1;
        check(req, q, exp);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: q=%b expected completion", q);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] seen;
        logic [3:0]  seed_v;
        logic [3:0]  hold_v;
        void'($urandom(32'd4711));
        rst = 1'b1; mode = 2'b00; ser_left = 1'b0; load_val = 4'h0; auto_seed = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        check("R1 reset", q, 4'b0000);
        @(negedge clk); rst = 1'b0;

        // R6: lock-up without auto-seed
        step(2'b01, 1'b0, 4'h0, 1'b0, "R6 lockup");
        step(2'b01, 1'b1, 4'hF, 1'b0, "R6 lockup");
        // R7: auto-seed escape
        step(2'b01, 1'b0, 4'h0, 1'b1, "R7 autoseed");
        check("R7 autoseed value", q, 4'b0001);

        // R9 load, R2 hold
        step(2'b11, 1'b0, 4'b1011, 1'b0, "R9 load");
        check("R9 load value", q, 4'b1011);
        step(2'b00, 1'b1, 4'b0110, 1'b1, "R2 hold");
        check("R2 hold value", q, 4'b1011);

        // R3/R4 directed: 1011 -> {011, 1^0} = 0111
        step(2'b01, 1'b0, 4'h0, 1'b0, "R3 R4 shift right");
        check("R4 feedback value", q, 4'b0111);
        // R8 directed: 0111 with ser_left=1 -> 1011
        step(2'b10, 1'b1, 4'h0, 1'b0, "R8 shift left");
        check("R8 shift left value", q, 4'b1011);

        // R11: auto-seed on a nonzero value acts like plain feedback
        step(2'b01, 1'b0, 4'h0, 1'b1, "R11 seed ignored");

        // R5: period and coverage from several seeds
        for (int s = 0; s < 4; s++) begin
            seed_v = 4'($urandom_range(1, 15));
            step(2'b11, 1'b0, seed_v, 1'b0, "R5 seed load");
            seen = 16'h0;
            for (int k = 1; k <= 15; k++) begin
                step(2'b01, 1'b0, 4'h0, 1'b0, "R5 step");
                seen[q] = 1'b1;
                n_chk++;
                if ((k < 15) && (q == seed_v)) begin
                    n_fail++;
                    $display("FAIL R5 early return at step %0d: q=%b expected not %b", k, q, seed_v);
                end
            end
            check("R5 period", q, seed_v);
            n_chk++;
            if (seen != 16'hFFFE) begin
                n_fail++;
                $display("FAIL R5 coverage: seen=%h expected %h", seen, 16'hFFFE);
            end
        end

        // R10: inputs changed mid-cycle do not reach q before the edge
        @(negedge clk);
        hold_v = q;
        mode = 2'b11; load_val = ~hold_v;
        #2;
        check("R10 no change between edges", q, hold_v);
        @(posedge clk); #1;
        check("R10 load at edge", q, ~hold_v);

        // Random mix of all modes
        for (int i = 0; i < 400; i++) begin
            step(2'($urandom), 1'($urandom), 4'($urandom), 1'($urandom), "R2 R3 R4 R8 R9 random");
        end

        // R1 again from a nonzero state
        step(2'b11, 1'b0, 4'b1111, 1'b0, "R9 load");
        @(negedge clk); rst = 1'b1; mode = 2'b01;
        @(posedge clk); #1;
        check("R1 reset from nonzero", q, 4'b0000);
        @(negedge clk); rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule